// File: doc/BRIEF.md
# AUX Channel Request/Reply Byte Buffer

This block holds the bytes of one AUX channel transaction. Software loads a request through a single data-register port. Each access to that port carries a byte, a direction flag and an index-reset flag. The first byte written after an index reset lands at location 0. Each later byte lands at the next location. The first four bytes form the request header: the address nibble and read flag, then the middle address byte, then the low address byte, then the length minus one. Any payload bytes follow the header.

A transaction-control write starts the transfer. It carries a go bit and three options: I2C, no-send-address and no-send-stop. The go bit is accepted only when the header is well formed. When it is accepted, the block latches the decoded request, pulses a launch strobe to the serial engine and stays busy until the engine signals done. While busy, the engine reads request bytes by index, and reply bytes it receives are stored from location 0 upward. Afterwards, software resets the read index. Its first read returns a throwaway word. Each later read returns a reply byte together with its index, so software can stop as soon as the index is not the one it expected.

Top module: `aux_cmd_fifo`

## Requirements
- R1: After reset, busy_o, launch_o and hdr_err_o are 0, dreg_rdata_o is 16'hFF00 and every stored byte is 0.
- R2: A data write (dreg_wdata_i[8]=0) with index-reset (dreg_wdata_i[9]=1) stores dreg_wdata_i[7:0] at location 0. Each later data write stores at the next location, and tx_byte_o shows the byte stored at tx_idx_i.
- R3: The write index saturates at location DEPTH-1 (143): extra bytes overwrite that location, and a go on such a buffer is rejected.
- R4: On an accepted go, the block latches the request. req_addr_o is {byte0[3:0], byte1, byte2}, req_rd_o is byte0 bit 4, and req_len_o is byte3+1.
- R5: A go is rejected, with hdr_err_o set to 1 one cycle after the control write and no launch, in any of these cases:
  - fewer than 4 bytes are written;
  - byte0[7:5] is nonzero;
  - a read carries any payload;
  - a write's payload differs from its length;
  - the payload exceeds 124 bytes;
  - the length exceeds 16 (native) or 128 (I2C).
- R6: Control word bits are go=[0], I2C=[1], no-send-address=[2], no-send-stop=[3]. A control write with go set and a valid header makes launch_o a one-cycle pulse and busy_o 1 on the next cycle, with the options on i2c_o, no_addr_o and no_stop_o. A later valid go clears hdr_err_o.
- R7: While busy_o is 1, data-register writes and control writes are ignored. done_i clears busy_o on the next cycle.
- R8: While busy_o is 1, each rx_valid_i cycle stores rx_byte_i at the next reply location, starting from location 0.
- R9: A write with direction=read (bit 8) and index-reset (bit 9) makes the next read return 16'hFFFF without moving the read index. Each read after that returns {index[7:0], byte[7:0]} and advances the index.
- R10: A read at an index at or beyond the number of reply bytes received returns 16'hFF00.
- R11: A data-register access with direction=read and no index-reset changes neither stored bytes nor the read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dreg_wr_i | input | 1 | Data-register write strobe |
| dreg_wdata_i | input | 10 | {index-reset, direction, byte} |
| dreg_rd_i | input | 1 | Data-register read strobe (advances read index) |
| dreg_rdata_o | output | 16 | {index, byte} read word |
| tc_wr_i | input | 1 | Transaction-control write strobe |
| tc_wdata_i | input | 4 | {no-stop, no-addr, i2c, go} |
| launch_o | output | 1 | One-cycle start pulse to serial engine |
| busy_o | output | 1 | Transfer in flight |
| hdr_err_o | output | 1 | Last go rejected for a malformed header |
| i2c_o | output | 1 | I2C option |
| no_addr_o | output | 1 | No-send-address option |
| no_stop_o | output | 1 | No-send-stop option |
| req_addr_o | output | 20 | Latched request address |
| req_len_o | output | 9 | Latched request length |
| req_rd_o | output | 1 | Latched read flag |
| tx_idx_i | input | 8 | Engine read index into the buffer |
| tx_byte_o | output | 8 | Byte at tx_idx_i |
| rx_valid_i | input | 1 | Reply byte strobe |
| rx_byte_i | input | 8 | Reply byte |
| done_i | input | 1 | Transfer finished |

## Verification
launch_o, busy_o, hdr_err_o and the latched request fields are registered. They are therefore due at the first rising edge after the control write. done_i clears busy_o at the edge that samples it. tx_byte_o and dreg_rdata_o are combinational views of registered storage and pointers, so they reflect a write, reply byte or read strobe one edge after the strobe. The bench drives every strobe on a falling edge for one full cycle and samples at the next falling edge, which is exactly one rising edge later.

// File: rtl/aux_fifo_pkg.sv
package aux_fifo_pkg;
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned IDXW      = 8;

  typedef struct packed {
    logic no_stop;
    logic no_addr;
    logic i2c;
    logic go;
  } tc_t;

  typedef struct packed {
    logic [19:0] addr;
    logic [8:0]  len;
    logic        rd;
  } req_t;
endpackage

// File: rtl/aux_fifo_store.sv
module aux_fifo_store #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o,
  output logic [aux_fifo_pkg::HDR_BYTES*8-1:0] hdr_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i < AW'(DEPTH)) ? mem_q[raddr_a_i] : 8'h00;
  assign rdata_b_o = (raddr_b_i < AW'(DEPTH)) ? mem_q[raddr_b_i] : 8'h00;

  for (genvar g = 0; g < aux_fifo_pkg::HDR_BYTES; g++) begin : g_hdr
    assign hdr_o[g*8 +: 8] = mem_q[g];
  end
endmodule

// File: rtl/aux_fifo_sat_ptr.sv
module aux_fifo_sat_ptr #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned PW    = 8,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [PW-1:0] cnt_o,
  output logic [AW-1:0] addr_o
);
  logic [PW-1:0] cnt_q, base;

  assign base   = clr_i ? '0 : cnt_q;
  assign addr_o = (base >= PW'(DEPTH)) ? AW'(DEPTH-1) : base[AW-1:0];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= (base >= PW'(DEPTH)) ? base : base + PW'(1);
    end else if (clr_i) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/aux_fifo_rptr.sv
module aux_fifo_rptr #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic          discard_o
);
  logic [AW-1:0] ptr_q;
  logic          disc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      disc_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      disc_q <= 1'b1;
    end else if (adv_i) begin
      if (disc_q)                          disc_q <= 1'b0;
      else if (ptr_q != AW'(DEPTH-1))      ptr_q  <= ptr_q + AW'(1);
    end
  end

  assign ptr_o     = ptr_q;
  assign discard_o = disc_q;
endmodule

// File: rtl/aux_fifo_hdr_chk.sv
module aux_fifo_hdr_chk
  import aux_fifo_pkg::*;
#(
  parameter int unsigned PW         = 8,
  parameter int unsigned MAX_MSG    = 128,
  parameter int unsigned NATIVE_MAX = 16,
  parameter int unsigned I2C_MAX    = 128
) (
  input  logic [HDR_BYTES*8-1:0] hdr_i,
  input  logic [PW-1:0]          cnt_i,
  input  logic                   i2c_i,
  output logic                   ok_o,
  output req_t                   req_o
);
  logic [9:0] pl, len10, lim;
  logic       have_hdr, rsvd_ok, shape_ok;

  assign req_o.addr = {hdr_i[3:0], hdr_i[15:8], hdr_i[23:16]};
  assign req_o.rd   = hdr_i[4];
  assign req_o.len  = {1'b0, hdr_i[31:24]} + 9'd1;

  assign len10    = {1'b0, req_o.len};
  assign pl       = 10'(cnt_i) - 10'(HDR_BYTES);
  assign have_hdr = cnt_i >= PW'(HDR_BYTES);
  assign rsvd_ok  = hdr_i[7:5] == 3'b000;
  assign lim      = i2c_i ? 10'(I2C_MAX) : 10'(NATIVE_MAX);
  // reads carry no payload; writes carry exactly len bytes
  assign shape_ok = req_o.rd ? (pl == 10'd0) : (pl == len10);

  assign ok_o = have_hdr && rsvd_ok && shape_ok &&
                (pl <= 10'(MAX_MSG - HDR_BYTES)) && (len10 <= lim);
endmodule

// File: rtl/aux_cmd_fifo.sv
module aux_cmd_fifo
  import aux_fifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 144,
  parameter int unsigned MAX_MSG    = 128,
  parameter int unsigned NATIVE_MAX = 16,
  parameter int unsigned I2C_MAX    = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dreg_wr_i,
  input  logic [9:0]  dreg_wdata_i,
  input  logic        dreg_rd_i,
  output logic [15:0] dreg_rdata_o,
  input  logic        tc_wr_i,
  input  logic [3:0]  tc_wdata_i,
  output logic        launch_o,
  output logic        busy_o,
  output logic        hdr_err_o,
  output logic        i2c_o,
  output logic        no_addr_o,
  output logic        no_stop_o,
  output logic [19:0] req_addr_o,
  output logic [8:0]  req_len_o,
  output logic        req_rd_o,
  input  logic [7:0]  tx_idx_i,
  output logic [7:0]  tx_byte_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        done_i
);
  localparam int unsigned AW = IDXW;
  localparam int unsigned PW = $clog2(DEPTH + 1);

  logic          busy_q, launch_q, err_q;
  tc_t           opt_q, tc_w;
  req_t          req_q, req_c;
  logic          hdr_ok;

  logic          dir_rd, idx_rst, dw_ok, rd_rst, rx_acc, tc_take, start;
  logic [PW-1:0] w_cnt, rx_cnt;
  logic [AW-1:0] w_addr, rx_addr, rd_ptr;
  logic          discard;
  logic [7:0]    rd_byte;
  logic [HDR_BYTES*8-1:0] hdr;

  assign tc_w    = tc_t'(tc_wdata_i);
  assign dir_rd  = dreg_wdata_i[8];
  assign idx_rst = dreg_wdata_i[9];
  assign dw_ok   = dreg_wr_i & ~busy_q & ~dir_rd;
  assign rd_rst  = dreg_wr_i & ~busy_q & dir_rd & idx_rst;
  assign rx_acc  = rx_valid_i & busy_q;
  assign tc_take = tc_wr_i & ~busy_q;
  assign start   = tc_take & tc_w.go & hdr_ok;

  aux_fifo_sat_ptr #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_wptr (
    .clk_i, .rst_ni,
    .clr_i (dw_ok & idx_rst),
    .inc_i (dw_ok),
    .cnt_o (w_cnt),
    .addr_o(w_addr)
  );

  aux_fifo_sat_ptr #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_rxptr (
    .clk_i, .rst_ni,
    .clr_i (start),
    .inc_i (rx_acc),
    .cnt_o (rx_cnt),
    .addr_o(rx_addr)
  );

  aux_fifo_rptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i, .rst_ni,
    .clr_i    (rd_rst),
    .adv_i    (dreg_rd_i),
    .ptr_o    (rd_ptr),
    .discard_o(discard)
  );

  aux_fifo_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i, .rst_ni,
    .we_i     (dw_ok | rx_acc),
    .waddr_i  (busy_q ? rx_addr : w_addr),
    .wdata_i  (busy_q ? rx_byte_i : dreg_wdata_i[7:0]),
    .raddr_a_i(tx_idx_i),
    .rdata_a_o(tx_byte_o),
    .raddr_b_i(rd_ptr),
    .rdata_b_o(rd_byte),
    .hdr_o    (hdr)
  );

  aux_fifo_hdr_chk #(
    .PW(PW), .MAX_MSG(MAX_MSG), .NATIVE_MAX(NATIVE_MAX), .I2C_MAX(I2C_MAX)
  ) u_hdr (
    .hdr_i(hdr),
    .cnt_i(w_cnt),
    .i2c_i(tc_w.i2c),
    .ok_o (hdr_ok),
    .req_o(req_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
      err_q    <= 1'b0;
      opt_q    <= '0;
      req_q    <= '0;
    end else begin
      launch_q <= start;
      if (tc_take) begin
        opt_q <= tc_w;
        err_q <= tc_w.go & ~hdr_ok;
      end
      if (start) begin
        busy_q <= 1'b1;
        req_q  <= req_c;
      end else if (busy_q && done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (discard)                    dreg_rdata_o = 16'hFFFF;
    else if (PW'(rd_ptr) < rx_cnt)  dreg_rdata_o = {8'(rd_ptr), rd_byte};
    else                            dreg_rdata_o = 16'hFF00;
  end

  assign launch_o   = launch_q;
  assign busy_o     = busy_q;
  assign hdr_err_o  = err_q;
  assign i2c_o      = opt_q.i2c;
  assign no_addr_o  = opt_q.no_addr;
  assign no_stop_o  = opt_q.no_stop;
  assign req_addr_o = req_q.addr;
  assign req_len_o  = req_q.len;
  assign req_rd_o   = req_q.rd;
endmodule

// File: rtl/aux_cmd_fifo_chk.sv
module aux_cmd_fifo_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          launch_o,
  input logic          hdr_err_o,
  input logic          done_i,
  input logic          tc_wr_i,
  input logic          rx_valid_i,
  input logic [AW-1:0] tx_idx_i,
  input logic [7:0]    tx_byte_o
);
  // R6
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);

  // R6
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> busy_o);

  // R6
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !tc_wr_i) |=> !busy_o);

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> busy_o);

  // R5
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |-> !busy_o);

  // R7
  busy_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rx_valid_i) |=>
      (tx_byte_o == $past(tx_byte_o) || tx_idx_i != $past(tx_idx_i)));
endmodule

bind aux_cmd_fifo aux_cmd_fifo_chk #(.AW(AW)) chk_i (.*);

// File: tb/aux_cmd_fifo_tb_top.sv
module aux_cmd_fifo_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        dreg_wr = 0, dreg_rd = 0, tc_wr = 0, rx_valid = 0, done = 0;
  logic [9:0]  dreg_wdata = '0;
  logic [3:0]  tc_wdata = '0;
  logic [7:0]  tx_idx = '0, rx_byte = '0;
  logic [15:0] rdata;
  logic        launch, busy, hdr_err, i2c, no_addr, no_stop, req_rd;
  logic [19:0] req_addr;
  logic [8:0]  req_len;
  logic [7:0]  tx_byte;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  aux_cmd_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .dreg_wr_i(dreg_wr), .dreg_wdata_i(dreg_wdata), .dreg_rd_i(dreg_rd),
    .dreg_rdata_o(rdata), .tc_wr_i(tc_wr), .tc_wdata_i(tc_wdata),
    .launch_o(launch), .busy_o(busy), .hdr_err_o(hdr_err),
    .i2c_o(i2c), .no_addr_o(no_addr), .no_stop_o(no_stop),
    .req_addr_o(req_addr), .req_len_o(req_len), .req_rd_o(req_rd),
    .tx_idx_i(tx_idx), .tx_byte_o(tx_byte),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .done_i(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dwr(input logic [7:0] b, input logic dir, input logic idx);
    dreg_wr = 1; dreg_wdata = {idx, dir, b};
    @(negedge clk); dreg_wr = 0;
  endtask

  task automatic tcw(input logic [3:0] w);
    tc_wr = 1; tc_wdata = w;
    @(negedge clk); tc_wr = 0;
  endtask

  task automatic rdp();
    dreg_rd = 1; @(negedge clk); dreg_rd = 0;
  endtask

  task automatic fin();
    done = 1; @(negedge clk); done = 0;
  endtask

  task automatic peek(input logic [7:0] i, output logic [7:0] b);
    tx_idx = i; #1; b = tx_byte;
  endtask

  // {i2c, ok, hdr0, hdr3, payload_len}
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h05, 8'd3,   8'd4},    // native write len 4
    {1'b0, 1'b1, 8'h1A, 8'd15,  8'd0},    // native read len 16
    {1'b0, 1'b0, 8'h1A, 8'd16,  8'd0},    // native read len 17
    {1'b0, 1'b0, 8'h00, 8'd3,   8'd2},    // payload short of len
    {1'b0, 1'b0, 8'h10, 8'd0,   8'd1},    // read with payload
    {1'b1, 1'b1, 8'h00, 8'd123, 8'd124},  // i2c write 124
    {1'b1, 1'b0, 8'h00, 8'd124, 8'd125},  // payload 125
    {1'b1, 1'b1, 8'h13, 8'd127, 8'd0},    // i2c read 128
    {1'b1, 1'b0, 8'h13, 8'd128, 8'd0},    // i2c read 129
    {1'b0, 1'b1, 8'h0F, 8'd15,  8'd16},   // native write 16
    {1'b0, 1'b0, 8'h25, 8'd3,   8'd4}     // reserved bit set
  };

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 launch", launch, 0);
    chk("R1 hdr_err", hdr_err, 0);
    chk("R1 rdata", rdata, 16'hFF00);
    peek(8'd0, b); chk("R1 mem0", b, 0);

    // vector walk: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic ci2c, cok;
      logic [7:0] h0, h3, pl;
      {ci2c, cok, h0, h3, pl} = VEC[v];
      dwr(h0, 0, 1); dwr(8'h12, 0, 0); dwr(8'h34, 0, 0); dwr(h3, 0, 0);
      for (int k = 0; k < int'(pl); k++) dwr(8'(k + v), 0, 0);
      tcw({2'b00, ci2c, 1'b1});
      chk($sformatf("R6 launch v%0d", v), launch, cok);
      chk($sformatf("R5 hdr_err v%0d", v), hdr_err, !cok);
      if (cok) begin
        chk($sformatf("R4 addr v%0d", v), req_addr, {h0[3:0], 16'h1234});
        chk($sformatf("R4 len v%0d", v), req_len, {1'b0, h3} + 9'd1);
        chk($sformatf("R4 rd v%0d", v), req_rd, h0[4]);
        fin();
        chk($sformatf("R7 done v%0d", v), busy, 0);
      end else begin
        chk($sformatf("R5 busy v%0d", v), busy, 0);
      end
    end

    // R2 sequential placement
    dwr(8'hA0, 0, 1); dwr(8'hA1, 0, 0); dwr(8'hA2, 0, 0);
    peek(8'd0, b); chk("R2 loc0", b, 8'hA0);
    peek(8'd2, b); chk("R2 loc2", b, 8'hA2);
    dwr(8'hB0, 0, 1);
    peek(8'd0, b); chk("R2 idx reset", b, 8'hB0);
    peek(8'd1, b); chk("R2 loc1 kept", b, 8'hA1);

    // R3 saturation
    dwr(8'd0, 0, 1);
    for (int i = 1; i < 150; i++) dwr(8'(i), 0, 0);
    peek(8'd143, b); chk("R3 last loc", b, 8'd149);
    peek(8'd142, b); chk("R3 loc142", b, 8'd142);
    tcw(4'h3);
    chk("R3 go rejected", hdr_err, 1);

    // R7 ignored while busy
    dwr(8'h00, 0, 1); dwr(8'h00, 0, 0); dwr(8'h10, 0, 0); dwr(8'h00, 0, 0);
    dwr(8'h5A, 0, 0);
    tcw(4'h1);
    chk("R7 busy", busy, 1);
    chk("R6 err cleared", hdr_err, 0);
    dwr(8'hAA, 0, 1);
    peek(8'd0, b); chk("R7 write ignored", b, 8'h00);
    peek(8'd4, b); chk("R7 payload kept", b, 8'h5A);
    tcw(4'hF);
    chk("R7 tc ignored", i2c, 0);
    chk("R7 still busy", busy, 1);
    fin();
    chk("R7 done clears", busy, 0);

    // R8 R9 R10 reply path
    dwr(8'h10, 0, 1); dwr(8'h00, 0, 0); dwr(8'h20, 0, 0); dwr(8'h02, 0, 0);
    tcw(4'h1);
    chk("R4 read addr", req_addr, 20'h00020);
    chk("R4 read len", req_len, 9'd3);
    rx_valid = 1; rx_byte = 8'h11; @(negedge clk);
    rx_byte = 8'h22; @(negedge clk);
    rx_byte = 8'h33; @(negedge clk);
    rx_valid = 0;
    peek(8'd0, b); chk("R8 rx0", b, 8'h11);
    peek(8'd2, b); chk("R8 rx2", b, 8'h33);
    fin();
    dwr(8'h00, 1, 1);
    chk("R9 throwaway", rdata, 16'hFFFF);
    rdp(); chk("R9 idx0", rdata, 16'h0011);
    rdp(); chk("R9 idx1", rdata, 16'h0122);
    rdp(); chk("R9 idx2", rdata, 16'h0233);
    rdp(); chk("R10 beyond", rdata, 16'hFF00);

    // R11 read-direction access without index reset
    dwr(8'h77, 1, 0);
    chk("R11 rdata", rdata, 16'hFF00);
    peek(8'd0, b); chk("R11 mem0", b, 8'h11);

    // R6 options
    dwr(8'h00, 0, 1); dwr(8'h00, 0, 0); dwr(8'h50, 0, 0); dwr(8'h00, 0, 0);
    dwr(8'h01, 0, 0);
    tcw(4'hF);
    chk("R6 launch", launch, 1);
    chk("R6 i2c", i2c, 1);
    chk("R6 no_addr", no_addr, 1);
    chk("R6 no_stop", no_stop, 1);
    @(negedge clk);
    chk("R6 pulse ends", launch, 0);
    fin();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule